// File: doc/BRIEF.md
# FIFO Flag Threshold Register Loader

This block keeps the two threshold values that a FIFO's partial-flag logic compares against: one sets how close to empty the almost-empty flag switches, the other how close to full the almost-full flag switches. The thresholds are presented continuously on two output buses so that the comparators can use them. The FIFO memory and the comparators themselves are not part of this block.

At master reset, the level of the load select pin picks both the reset value of the thresholds and the way they are programmed later. Low gives a small default and word-wide programming from the write data bus. High gives a large default and programming one bit at a time through a serial input. After reset, words or bits go into the almost-empty threshold first and then into the almost-full threshold, and the sequence then starts again. On the read clock the same sequence can be read back one word at a time. A partial reset restarts both sequences and leaves the thresholds and the programming method unchanged.

Both resets are synchronous and are seen on each clock. Host logic must not change the thresholds while a readback on the read clock is in progress.

Top module: `flag_offset_loader`

## Requirements
- R1: When master reset is sampled high with the load select low, both thresholds become 127 at the next write-clock edge and word-wide (parallel) programming is selected.
- R2: When master reset is sampled high with the load select high, both thresholds become 1023 at the next write-clock edge and serial programming is selected.
- R3: In serial mode, each write-clock edge with serial enable and load select both high stores the serial input bit into the next bit of the active threshold. Bits go least significant first, 17 bits to almost-empty, then 17 bits to almost-full, and then the sequence returns to almost-empty.
- R4: In parallel mode, each write-clock edge with write enable and load select both high stores a 9-bit write word into the next segment. Segment 0 is threshold bits 8:0 and takes the whole word. Segment 1 is bits 16:9 and takes word bits 7:0. The order is almost-empty segment 0, almost-empty segment 1, almost-full segment 0, almost-full segment 1, and then the sequence wraps.
- R5: Programming strobes of the method that is not selected, and any strobe while the load select is low, leave both thresholds unchanged.
- R6: A read-clock edge with read enable and load select both high puts the next readback word on the read data output at that edge. Readback follows the R4 segment order, and the upper 1 bit of segment 1 reads as zero. When no readback occurs, the read data output holds its value and is 0 after master reset.
- R7: Partial reset keeps both thresholds and the programming method, and returns both the write sequence and the readback sequence to almost-empty segment 0 (bit 0 in serial mode).
- R8: Master reset also returns the write sequence and the readback sequence to their start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wrClk | input | 1 | Write-side clock |
| rdClk | input | 1 | Read-side clock |
| masterRst | input | 1 | Synchronous master reset, active high |
| partialRst | input | 1 | Synchronous partial reset, active high |
| loadSel | input | 1 | Load select: chooses the mode during master reset and qualifies every load or readback |
| serialEn | input | 1 | Serial shift enable |
| serialIn | input | 1 | Serial data bit |
| wrEn | input | 1 | Parallel write enable |
| wrData | input | 9 | Parallel write word |
| rdEn | input | 1 | Readback enable |
| rdData | output | 9 | Readback word |
| aeOffset | output | 17 | Almost-empty threshold |
| afOffset | output | 17 | Almost-full threshold |

## Verification
The bench uses the default widths: 9-bit words, 17-bit thresholds and defaults of 127 and 1023. With these widths each threshold spans two segments and the upper segment is partly filled, so the segment truncation, the zero padding on readback and the wrap from almost-full back to almost-empty all occur within a few dozen cycles. The two clocks run at unrelated periods so that readback timing depends only on the read clock. A full 34-bit serial pass and partial resets in the middle of a sequence cover the bit order and the points where the sequence restarts.

// File: rtl/flagoff_pkg.sv
package flagoff_pkg;
  localparam int IDX_W = 8;

  typedef struct packed {
    logic             defLoad;
    logic             defHigh;
    logic             serShift;
    logic             serTgt;
    logic [IDX_W-1:0] serBit;
    logic             parWrite;
    logic             parTgt;
    logic [IDX_W-1:0] parSeg;
  } wrStrobe_t;

  typedef struct packed {
    logic             rdRst;
    logic             rdLoad;
    logic             rdTgt;
    logic [IDX_W-1:0] rdSeg;
  } rdStrobe_t;
endpackage

// File: rtl/flagoff_ctrl.sv
module flagoff_ctrl
  import flagoff_pkg::*;
#(
  parameter int DATA_W = 9,
  parameter int OFF_W  = 17
) (
  input  logic      wrClk,
  input  logic      rdClk,
  input  logic      masterRst,
  input  logic      partialRst,
  input  logic      loadSel,
  input  logic      serialEn,
  input  logic      wrEn,
  input  logic      rdEn,
  output wrStrobe_t wrStb,
  output rdStrobe_t rdStb
);
  localparam int SEG_CNT = (OFF_W + DATA_W - 1) / DATA_W;
  localparam int SEG_W   = (SEG_CNT > 1) ? $clog2(SEG_CNT) : 1;
  localparam int BIT_W   = (OFF_W > 1) ? $clog2(OFF_W) : 1;

  logic             serialMode;
  logic             wrTgt;
  logic [SEG_W-1:0] wrSeg;
  logic [BIT_W-1:0] serBit;
  logic             rdTgt;
  logic [SEG_W-1:0] rdSeg;

  logic wrSeqRst, doShift, doPar, doRead, rdSeqRst;

  assign wrSeqRst = masterRst || partialRst;
  assign doShift  = !wrSeqRst && serialMode && serialEn && loadSel;
  assign doPar    = !wrSeqRst && !serialMode && wrEn && loadSel;
  assign rdSeqRst = masterRst || partialRst;
  assign doRead   = !rdSeqRst && rdEn && loadSel;

  // write-side sequence
  always_ff @(posedge wrClk) begin
    if (masterRst) begin
      serialMode <= loadSel;
      wrTgt      <= 1'b0;
      wrSeg      <= '0;
      serBit     <= '0;
    end else if (partialRst) begin
      wrTgt  <= 1'b0;
      wrSeg  <= '0;
      serBit <= '0;
    end else if (doShift) begin
      if (serBit == BIT_W'(OFF_W - 1)) begin
        serBit <= '0;
        wrTgt  <= ~wrTgt;
      end else begin
        serBit <= serBit + 1'b1;
      end
    end else if (doPar) begin
      if (wrSeg == SEG_W'(SEG_CNT - 1)) begin
        wrSeg <= '0;
        wrTgt <= ~wrTgt;
      end else begin
        wrSeg <= wrSeg + 1'b1;
      end
    end
  end

  // read-side sequence
  always_ff @(posedge rdClk) begin
    if (rdSeqRst) begin
      rdTgt <= 1'b0;
      rdSeg <= '0;
    end else if (doRead) begin
      if (rdSeg == SEG_W'(SEG_CNT - 1)) begin
        rdSeg <= '0;
        rdTgt <= ~rdTgt;
      end else begin
        rdSeg <= rdSeg + 1'b1;
      end
    end
  end

  always_comb begin
    wrStb          = '0;
    wrStb.defLoad  = masterRst;
    wrStb.defHigh  = loadSel;
    wrStb.serShift = doShift;
    wrStb.serTgt   = wrTgt;
    wrStb.serBit   = IDX_W'(serBit);
    wrStb.parWrite = doPar;
    wrStb.parTgt   = wrTgt;
    wrStb.parSeg   = IDX_W'(wrSeg);
    rdStb          = '0;
    rdStb.rdRst    = masterRst;
    rdStb.rdLoad   = doRead;
    rdStb.rdTgt    = rdTgt;
    rdStb.rdSeg    = IDX_W'(rdSeg);
  end

  // R7: partial reset restarts the write sequence
  p_prs_ptr_r7: assert property (@(posedge wrClk) disable iff (masterRst)
    partialRst |=> (wrSeg == '0 && serBit == '0 && !wrTgt));

  // R7: partial reset keeps the programming method
  p_mode_kept_r7: assert property (@(posedge wrClk) disable iff (masterRst)
    partialRst |=> $stable(serialMode));

  // R7: partial reset restarts readback
  p_rd_prs_r7: assert property (@(posedge rdClk) disable iff (masterRst)
    partialRst |=> (rdSeg == '0 && !rdTgt));

  // R3: the last serial bit moves the sequence to the other threshold
  p_ser_wrap_r3: assert property (@(posedge wrClk) disable iff (masterRst)
    (doShift && serBit == BIT_W'(OFF_W - 1)) |=> (wrTgt != $past(wrTgt) && serBit == '0));
endmodule

// File: rtl/flagoff_datapath.sv
module flagoff_datapath
  import flagoff_pkg::*;
#(
  parameter int DATA_W   = 9,
  parameter int OFF_W    = 17,
  parameter int DEF_LOW  = 127,
  parameter int DEF_HIGH = 1023
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  wrStrobe_t         wrStb,
  input  rdStrobe_t         rdStb,
  input  logic              serialIn,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic [OFF_W-1:0]  aeOffset,
  output logic [OFF_W-1:0]  afOffset
);
  localparam int SEG_CNT = (OFF_W + DATA_W - 1) / DATA_W;
  localparam int PAD_W   = SEG_CNT * DATA_W;

  logic [OFF_W-1:0]  aeReg, afReg, aeNext, afNext, tgtVal, tgtNext;
  logic [PAD_W-1:0]  rdPadded;
  logic [DATA_W-1:0] rdWord;

  always_comb begin
    aeNext  = aeReg;
    afNext  = afReg;
    tgtVal  = (wrStb.serShift ? wrStb.serTgt : wrStb.parTgt) ? afReg : aeReg;
    tgtNext = tgtVal;
    if (wrStb.serShift) begin
      for (int b = 0; b < OFF_W; b++)
        if (wrStb.serBit == IDX_W'(b)) tgtNext[b] = serialIn;
    end else if (wrStb.parWrite) begin
      for (int b = 0; b < OFF_W; b++)
        if (wrStb.parSeg == IDX_W'(b / DATA_W)) tgtNext[b] = wrData[b % DATA_W];
    end
    if (wrStb.defLoad) begin
      aeNext = wrStb.defHigh ? OFF_W'(DEF_HIGH) : OFF_W'(DEF_LOW);
      afNext = aeNext;
    end else if (wrStb.serShift || wrStb.parWrite) begin
      if (wrStb.serShift ? wrStb.serTgt : wrStb.parTgt) afNext = tgtNext;
      else                                              aeNext = tgtNext;
    end
  end

  always_ff @(posedge wrClk) begin
    aeReg <= aeNext;
    afReg <= afNext;
  end

  assign aeOffset = aeReg;
  assign afOffset = afReg;

  // readback word selection
  always_comb begin
    rdPadded = PAD_W'(rdStb.rdTgt ? afReg : aeReg);
    rdWord   = '0;
    for (int s = 0; s < SEG_CNT; s++)
      if (rdStb.rdSeg == IDX_W'(s)) rdWord = rdPadded[s*DATA_W +: DATA_W];
  end

  always_ff @(posedge rdClk) begin
    if (rdStb.rdRst)       rdData <= '0;
    else if (rdStb.rdLoad) rdData <= rdWord;
  end

  // R5: thresholds move only on a programming strobe
  p_hold_r5: assert property (@(posedge wrClk) disable iff (wrStb.defLoad)
    (!wrStb.serShift && !wrStb.parWrite) |=> ($stable(aeReg) && $stable(afReg)));

  // R6: read data holds without a readback
  p_rdhold_r6: assert property (@(posedge rdClk) disable iff (rdStb.rdRst)
    !rdStb.rdLoad |=> $stable(rdData));

  // R3: a serial shift changes at most one threshold bit
  p_one_bit_r3: assert property (@(posedge wrClk) disable iff (wrStb.defLoad)
    wrStb.serShift |=> ($countones({aeReg ^ $past(aeReg), afReg ^ $past(afReg)}) <= 1));
endmodule

// File: rtl/flag_offset_loader.sv
module flag_offset_loader
  import flagoff_pkg::*;
#(
  parameter int DATA_W   = 9,
  parameter int OFF_W    = 17,
  parameter int DEF_LOW  = 127,
  parameter int DEF_HIGH = 1023
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              masterRst,
  input  logic              partialRst,
  input  logic              loadSel,
  input  logic              serialEn,
  input  logic              serialIn,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdEn,
  output logic [DATA_W-1:0] rdData,
  output logic [OFF_W-1:0]  aeOffset,
  output logic [OFF_W-1:0]  afOffset
);
  wrStrobe_t wrStb;
  rdStrobe_t rdStb;

  flagoff_ctrl #(.DATA_W(DATA_W), .OFF_W(OFF_W)) ctrl_i (
    .wrClk(wrClk), .rdClk(rdClk), .masterRst(masterRst), .partialRst(partialRst),
    .loadSel(loadSel), .serialEn(serialEn), .wrEn(wrEn), .rdEn(rdEn),
    .wrStb(wrStb), .rdStb(rdStb)
  );

  flagoff_datapath #(.DATA_W(DATA_W), .OFF_W(OFF_W), .DEF_LOW(DEF_LOW), .DEF_HIGH(DEF_HIGH)) dp_i (
    .wrClk(wrClk), .rdClk(rdClk), .wrStb(wrStb), .rdStb(rdStb),
    .serialIn(serialIn), .wrData(wrData), .rdData(rdData),
    .aeOffset(aeOffset), .afOffset(afOffset)
  );
endmodule

// File: tb/flag_offset_loader_tb.sv
module flag_offset_loader_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int RD_PERIOD  = 14;
  localparam int DW = 9;
  localparam int OW = 17;

  logic wrClk = 0, rdClk = 0;
  logic masterRst = 1, partialRst = 0, loadSel = 0, serialEn = 0, serialIn = 0;
  logic wrEn = 0, rdEn = 0;
  logic [DW-1:0] wrData = '0;
  logic [DW-1:0] rdData;
  logic [OW-1:0] aeOffset, afOffset;

  int checks = 0, failures = 0;
  bit done = 0;

  // requirement model
  logic [OW-1:0] mAe, mAf;
  bit mSerial;
  int mWrIdx, mBit, mRdIdx;
  logic [DW-1:0] expQ[$];
  string tagQ[$];
  logic rdFire = 0;

  always #(CLK_PERIOD/2) wrClk = ~wrClk;
  always #(RD_PERIOD/2)  rdClk = ~rdClk;

  flag_offset_loader dut_i (
    .wrClk(wrClk), .rdClk(rdClk), .masterRst(masterRst), .partialRst(partialRst),
    .loadSel(loadSel), .serialEn(serialEn), .serialIn(serialIn), .wrEn(wrEn),
    .wrData(wrData), .rdEn(rdEn), .rdData(rdData), .aeOffset(aeOffset), .afOffset(afOffset)
  );

  task automatic check(string tag, logic [OW-1:0] act, logic [OW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic checkOffsets(string tag);
    @(negedge wrClk);
    check({tag, " ae"}, aeOffset, mAe);
    check({tag, " af"}, afOffset, mAf);
  endtask

  task automatic idleWr();
    @(negedge wrClk);
    wrEn = 0; serialEn = 0; loadSel = 0;
  endtask

  task automatic masterReset(bit sel);
    @(negedge wrClk);
    loadSel = sel; masterRst = 1; wrEn = 0; serialEn = 0;
    repeat (6) @(negedge wrClk);
    masterRst = 0; loadSel = 0;
    mAe = sel ? OW'(1023) : OW'(127); mAf = mAe;
    mSerial = sel; mWrIdx = 0; mBit = 0; mRdIdx = 0;
  endtask

  task automatic partialReset();
    @(negedge wrClk);
    partialRst = 1;
    repeat (5) @(negedge wrClk);
    partialRst = 0;
    mWrIdx = 0; mBit = 0; mRdIdx = 0;
  endtask

  task automatic parWord(logic [DW-1:0] w, bit withLoad);
    @(negedge wrClk);
    wrEn = 1; serialEn = 0; loadSel = withLoad; wrData = w;
    if (withLoad && !mSerial) begin
      logic [OW-1:0] v;
      v = (mWrIdx / 2) ? mAf : mAe;
      if (mWrIdx % 2 == 0) v[8:0] = w;
      else                 v[16:9] = w[7:0];
      if (mWrIdx / 2) mAf = v; else mAe = v;
      mWrIdx = (mWrIdx + 1) % 4;
    end
  endtask

  task automatic serBit(bit b);
    @(negedge wrClk);
    serialEn = 1; wrEn = 0; loadSel = 1; serialIn = b;
    if (mSerial) begin
      if (mBit >= OW) mAf[mBit-OW] = b; else mAe[mBit] = b;
      mBit = (mBit + 1) % (2*OW);
    end
  endtask

  function automatic logic [DW-1:0] segOf(int idx);
    logic [OW-1:0] v;
    logic [17:0] p;
    v = (idx / 2) ? mAf : mAe;
    p = {1'b0, v};
    return (idx % 2) ? p[17:9] : p[8:0];
  endfunction

  task automatic readWords(int n, string tag);
    for (int i = 0; i < n; i++) begin
      @(negedge rdClk);
      rdEn = 1; loadSel = 1;
      expQ.push_back(segOf(mRdIdx));
      tagQ.push_back(tag);
      mRdIdx = (mRdIdx + 1) % 4;
    end
    @(negedge rdClk);
    rdEn = 0; loadSel = 0;
    @(negedge rdClk);
  endtask

  // monitor
  always @(posedge rdClk) rdFire <= rdEn && loadSel && !masterRst && !partialRst;
  always @(negedge rdClk) begin
    if (rdFire) begin
      if (expQ.size() == 0) begin
        checks++; failures++;
        $display("FAIL R6 unexpected readback actual=%0h expected=none", rdData);
      end else begin
        logic [DW-1:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        check(t, OW'(rdData), OW'(e));
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R1 default low, parallel mode
    masterReset(0);
    checkOffsets("R1 defaults 127");
    check("R6 rdData reset", OW'(rdData), '0);
    readWords(4, "R6 readback defaults");

    // R4 parallel load, AE then AF, low segment first
    parWord(9'h1CD, 1); parWord(9'h0D5, 1); parWord(9'h145, 1); parWord(9'h1F1, 1);
    idleWr();
    checkOffsets("R4 parallel load");
    readWords(4, "R6 readback parallel");
    readWords(2, "R6 readback wrap");

    // R5 serial strobes and unqualified writes ignored in parallel mode
    serBit(1); serBit(0); serBit(1); parWord(9'h0AA, 0);
    idleWr();
    checkOffsets("R5 ignored strobes parallel");

    // R4 wrap back to almost-empty low segment
    parWord(9'h033, 1);
    idleWr();
    checkOffsets("R4 wrap");

    // R7 partial reset mid-sequence
    partialReset();
    checkOffsets("R7 offsets kept");
    parWord(9'h111, 1); parWord(9'h0EE, 1);
    idleWr();
    checkOffsets("R7 sequence restart parallel");
    readWords(1, "R7 readback before prs");
    partialReset();
    readWords(2, "R7 readback restart");

    // R2 default high, serial mode
    masterReset(1);
    checkOffsets("R2 defaults 1023");
    readWords(2, "R8 readback restart");

    // R3 full serial pass, LSB first
    begin
      logic [OW-1:0] a, f;
      a = 17'h0F0F1; f = 17'h1C3A5;
      for (int i = 0; i < OW; i++) serBit(a[i]);
      for (int i = 0; i < OW; i++) serBit(f[i]);
    end
    idleWr();
    checkOffsets("R3 serial load");
    readWords(4, "R6 readback serial");

    // R5 parallel writes ignored in serial mode
    parWord(9'h155, 1); parWord(9'h0AA, 1);
    idleWr();
    checkOffsets("R5 ignored parallel in serial");

    // R7 partial reset mid-serial keeps serial mode
    serBit(0); serBit(1); serBit(1);
    idleWr();
    partialReset();
    checkOffsets("R7 serial offsets kept");
    for (int i = 0; i < OW; i++) serBit(i % 3 == 0);
    idleWr();
    checkOffsets("R7 serial restart");

    // R8 master reset restarts serial sequence
    serBit(1); serBit(1); serBit(0); serBit(1); serBit(1);
    idleWr();
    masterReset(1);
    for (int i = 0; i < OW; i++) serBit(i % 2 == 1);
    idleWr();
    checkOffsets("R8 serial restart after master reset");

    repeat (4) @(negedge rdClk);
    if (expQ.size() != 0) begin
      checks++; failures++;
      $display("FAIL R6 pending readbacks actual=%0d expected=0", expQ.size());
    end
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule